// File: doc/BRIEF.md
# Four-port GPIO controller with pin event detection

This block drives and samples 32 general-purpose pins, grouped as four 8-bit ports numbered 0 to 3. The host reaches it over a single-cycle byte bus with two windows. The runtime window, selected when `bus_win` is 0, holds the data-out, data-in, event-enable and event-status registers. The configuration window, selected when `bus_win` is 1, is an index/data pair that reaches the configuration register of any one pin. Read data comes back from a register: `bus_rdata` shows, one clock after the edge that samples `bus_win` and `bus_addr`, the value of the register they address.

Ports 0 and 1 watch their pins for events. Each pin can watch for a rising or falling edge, or for a high or low level. An event sets a sticky status bit. Any status bit that is also enabled requests either `irq` or `smi`, as the pin's routing bit chooses. Ports 2 and 3 are plain I/O: they have only data registers, and their configuration registers are 4 bits wide. Every pin input passes through a two-flop synchronizer. Each pin output is given as a value and an enable, which come from the pin's configuration and support push-pull or open-drain drive.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: After reset, every data-out, enable, status, index and configuration register holds 0, and `pin_oe`, `pin_out`, `irq`, `smi` and `bus_rdata` are all 0.
- R2: The data-out registers sit at runtime offsets 00h (port 0), 04h (port 1), 08h (port 2) and 0Ah (port 3). They are read/write, and bit n drives pin n of its port (pin number = 8 × port + n).
- R3: The data-in registers sit at offsets 01h, 05h, 09h and 0Bh. Each reads its port's pins two clocks after they change. They are read-only: writes to them have no effect.
- R4: Runtime offsets 0Ch to 0Fh read as 0, and writes to them change no register.
- R5: Configuration bit 0 enables the output and bit 1 selects open-drain (1) or push-pull (0). In push-pull mode `pin_oe` equals bit 0 and `pin_out` equals the data-out bit. In open-drain mode the pin is enabled only while its data-out bit is 0. Both outputs are registered and follow a register write by one clock.
- R6: Configuration window offset 0 is the index register. Its bits 4:3 pick the port, bits 2:0 pick the pin, and bits 7:5 read as 0. Offset 1 reads and writes the 7-bit configuration of the indexed pin on ports 0 and 1.
- R7: On ports 2 and 3 only configuration bits 3:0 exist. Bits 6:4 read as 0 whatever was written.
- R8: With configuration bit 5 = 0 (edge mode), bit 4 selects a rising (1) or falling (0) edge. The event status bit for the pin is at offset 03h (port 0) or 07h (port 1). It becomes 1 three clocks after the pin changes, whether or not its enable bit is set.
- R9: With configuration bit 5 = 1 (level mode), the status bit is set again on every clock while the pin is at the level that bit 4 selects (1 = high), so clearing it has no lasting effect during that time.
- R10: Status bits are write-one-to-clear. Writing 1 clears the bit, writing 0 leaves it unchanged, and only such a write clears a status bit.
- R11: When an event and a write-one-to-clear hit the same status bit in the same clock, the bit ends up set.
- R12: The enable registers at offsets 02h (port 0) and 06h (port 1) are read/write. `irq` is 1 when some status bit is set, enabled, and has configuration bit 6 = 0. `smi` is the same for configuration bit 6 = 1. Both outputs are registered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_win | input | 1 | Window select: 0 runtime registers, 1 configuration index/data |
| bus_addr | input | 4 | Register offset within the selected window |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data of the addressed register |
| pin_in | input | 32 | Pin input levels, asynchronous to clk |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |
| irq | output | 1 | Interrupt request from enabled, IRQ-routed status bits |
| smi | output | 1 | System-management request from enabled, SMI-routed status bits |

## Verification
An edge event arriving from a pin can land in the same clock as a host write-one-to-clear to that same status bit. The bench provokes this by changing the pin on a falling clock edge and counting the two synchronizer stages and the edge register. It then issues the clearing write so that it is sampled on exactly the edge where the event is set. It judges the result by reading the status register back. The bit must first be set by an earlier event, so that a clear-wins design reads 0. A second run uses a clear with no coincident event, and expects 0, to show that the same write really does clear.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  // bus window offsets
  localparam int ADDR_W = 4;
  // configuration bit positions
  localparam int CB_OE  = 0;
  localparam int CB_OD  = 1;
  localparam int CB_POL = 4;
  localparam int CB_LVL = 5;
  localparam int CB_SMI = 6;
  localparam int CFG_FULL = 7;
  localparam int CFG_LITE = 4;

  // runtime map: event ports first (4 registers each), then plain ports (2 each)
  function automatic logic [ADDR_W-1:0] do_ofs(input int k, input int nevt);
    if (k < nevt) return ADDR_W'(4 * k);
    return ADDR_W'(4 * nevt + 2 * (k - nevt));
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_evt_port.sv
module gpio_evt_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sin,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] route_smi,
  input  logic         en_wr,
  input  logic         st_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic [W-1:0] st_q,
  output logic         irq_req,
  output logic         smi_req
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit;
  logic [W-1:0] clr_m;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      if (lvl[i]) hit[i] = pol[i] ? sin[i] : ~sin[i];
      else        hit[i] = pol[i] ? (sin[i] & ~prev_q[i]) : (~sin[i] & prev_q[i]);
    end
  end

  assign clr_m = st_wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      en_q   <= '0;
      st_q   <= '0;
    end else begin
      prev_q <= sin;
      if (en_wr) en_q <= wdata;
      st_q <= (st_q & ~clr_m) | hit;
    end
  end

  assign irq_req = |(st_q & en_q & ~route_smi);
  assign smi_req = |(st_q & en_q & route_smi);

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((st_q & $past(hit)) == $past(hit)));

  // R10
  st_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~st_q & $past(st_q) & ~$past(clr_m)) == '0));
endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int NPORT     = 4,
  parameter int EVT_NPORT = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_win,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic [PORT_W-1:0]       bus_wdata,
  output logic [PORT_W-1:0]       bus_rdata,
  input  logic [PORT_W*NPORT-1:0] pin_in,
  output logic [PORT_W*NPORT-1:0] pin_out,
  output logic [PORT_W*NPORT-1:0] pin_oe,
  output logic                    irq,
  output logic                    smi
);
  localparam int NPINS     = PORT_W * NPORT;
  localparam int PIN_BITS  = $clog2(PORT_W);
  localparam int PORT_BITS = $clog2(NPORT);
  localparam int IDX_W     = PIN_BITS + PORT_BITS;

  logic [NPINS-1:0]     s_in;
  logic [PORT_W-1:0]    do_q [NPORT];
  logic [IDX_W-1:0]     idx_q;
  logic [CFG_FULL-1:0]  cfg_v [NPINS];
  logic [NPINS-1:0]     od_vec;
  logic [PORT_W-1:0]    en_v [EVT_NPORT];
  logic [PORT_W-1:0]    st_v [EVT_NPORT];
  logic [EVT_NPORT-1:0] irq_r, smi_r;
  logic [EVT_NPORT-1:0][PORT_W-1:0] pol_m, lvl_m, smi_m;
  logic [PORT_W-1:0]    rd_nx;
  logic                 rt_wr, cfg_wr;

  assign rt_wr  = bus_wr & ~bus_win;
  assign cfg_wr = bus_wr & bus_win;

  gpio_sync #(.W(NPINS)) u_sync (.clk(clk), .rst(rst), .d(pin_in), .q(s_in));

  // per-pin configuration; plain ports keep only the low bits
  for (genvar p = 0; p < NPINS; p++) begin : g_cfg
    localparam int CW = ((p / PORT_W) < EVT_NPORT) ? CFG_FULL : CFG_LITE;
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(p);
    logic [CW-1:0] cfg_r;
    always_ff @(posedge clk) begin
      if (rst) cfg_r <= '0;
      else if (cfg_wr && bus_addr == ADDR_W'(1) && idx_q == MY_IDX) cfg_r <= bus_wdata[CW-1:0];
    end
    assign cfg_v[p]  = CFG_FULL'(cfg_r);
    assign od_vec[p] = cfg_v[p][CB_OD];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      for (int k = 0; k < NPORT; k++) do_q[k] <= '0;
    end else begin
      if (cfg_wr && bus_addr == '0) idx_q <= bus_wdata[IDX_W-1:0];
      if (rt_wr)
        for (int k = 0; k < NPORT; k++)
          if (bus_addr == do_ofs(k, EVT_NPORT)) do_q[k] <= bus_wdata;
    end
  end

  for (genvar e = 0; e < EVT_NPORT; e++) begin : g_evt
    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
      assign pol_m[e][b] = cfg_v[e*PORT_W+b][CB_POL];
      assign lvl_m[e][b] = cfg_v[e*PORT_W+b][CB_LVL];
      assign smi_m[e][b] = cfg_v[e*PORT_W+b][CB_SMI];
    end
    gpio_evt_port #(.W(PORT_W)) u_evt (
      .clk(clk), .rst(rst),
      .sin(s_in[e*PORT_W +: PORT_W]),
      .pol(pol_m[e]), .lvl(lvl_m[e]), .route_smi(smi_m[e]),
      .en_wr(rt_wr && bus_addr == ADDR_W'(4*e+2)),
      .st_wr(rt_wr && bus_addr == ADDR_W'(4*e+3)),
      .wdata(bus_wdata),
      .en_q(en_v[e]), .st_q(st_v[e]),
      .irq_req(irq_r[e]), .smi_req(smi_r[e])
    );
  end

  always_comb begin
    rd_nx = '0;
    if (!bus_win) begin
      for (int k = 0; k < NPORT; k++) begin
        if (bus_addr == do_ofs(k, EVT_NPORT))       rd_nx = do_q[k];
        if (bus_addr == do_ofs(k, EVT_NPORT) + 1'b1) rd_nx = s_in[k*PORT_W +: PORT_W];
      end
      for (int e = 0; e < EVT_NPORT; e++) begin
        if (bus_addr == ADDR_W'(4*e+2)) rd_nx = en_v[e];
        if (bus_addr == ADDR_W'(4*e+3)) rd_nx = st_v[e];
      end
    end else if (bus_addr == '0) begin
      rd_nx = PORT_W'(idx_q);
    end else if (bus_addr == ADDR_W'(1)) begin
      rd_nx = PORT_W'(cfg_v[idx_q]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      pin_out   <= '0;
      pin_oe    <= '0;
      irq       <= 1'b0;
      smi       <= 1'b0;
    end else begin
      bus_rdata <= rd_nx;
      for (int p = 0; p < NPINS; p++) begin
        pin_out[p] <= do_q[p / PORT_W][p % PORT_W];
        pin_oe[p]  <= cfg_v[p][CB_OE] & (~cfg_v[p][CB_OD] | ~do_q[p / PORT_W][p % PORT_W]);
      end
      irq <= |irq_r;
      smi <= |smi_r;
    end
  end

  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(bus_win) && $past(bus_addr) >= ADDR_W'(4*EVT_NPORT + 2*(NPORT-EVT_NPORT)))
      |-> (bus_rdata == '0));

  // R7
  lite_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_win) && $past(bus_addr) == ADDR_W'(1) && $past(idx_q[IDX_W-1]))
      |-> (bus_rdata[PORT_W-1:CFG_LITE] == '0));

  // R5
  open_drain_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_oe & pin_out & $past(od_vec)) == '0));
endmodule

// File: tb/gpio_evt_ctrl_test.sv
module gpio_evt_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_win = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq, smi;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  gpio_evt_ctrl uut (
    .clk(clk), .rst(rst), .bus_win(bus_win), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .smi(smi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic win, input logic [3:0] a, input logic [7:0] d);
    bus_win = win; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic win, input logic [3:0] a, output logic [7:0] d);
    bus_win = win; bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 pin_oe", pin_oe, 0);
    check("R1 pin_out", pin_out, 0);
    check("R1 irq/smi", {irq, smi}, 0);
    rd(0, 4'h0, v); check("R1 DO0", v, 0);
    rd(0, 4'h3, v); check("R1 ST0", v, 0);
    rd(1, 4'h1, v); check("R1 cfg", v, 0);
  endtask

  task automatic t_data_out();
    logic [7:0] v;
    wr(0, 4'h0, 8'hA5); wr(0, 4'h4, 8'h3C); wr(0, 4'h8, 8'h5A); wr(0, 4'hA, 8'hC3);
    rd(0, 4'h0, v); check("R2 DO0", v, 8'hA5);
    rd(0, 4'h4, v); check("R2 DO1", v, 8'h3C);
    rd(0, 4'h8, v); check("R2 DO2", v, 8'h5A);
    rd(0, 4'hA, v); check("R2 DO3", v, 8'hC3);
    wait_n(1);
    check("R2 pin_out", pin_out, 32'hC35A3CA5);
  endtask

  task automatic t_data_in();
    logic [7:0] v;
    wr(0, 4'h1, 8'hFF);
    rd(0, 4'h1, v); check("R3 DI0 write ignored", v, 8'h00);
    pin_in = 32'h12345678;
    wait_n(3);
    rd(0, 4'h1, v); check("R3 DI0", v, 8'h78);
    rd(0, 4'h5, v); check("R3 DI1", v, 8'h56);
    rd(0, 4'h9, v); check("R3 DI2", v, 8'h34);
    rd(0, 4'hB, v); check("R3 DI3", v, 8'h12);
    pin_in = '0;
    wait_n(4);
    rd(0, 4'h3, v); check("R8 default falling ST0", v, 8'h78);
    wr(0, 4'h3, 8'hFF); wr(0, 4'h7, 8'hFF);
    rd(0, 4'h3, v); check("R10 ST0 cleared", v, 8'h00);
    rd(0, 4'h7, v); check("R10 ST1 cleared", v, 8'h00);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    for (int a = 12; a < 16; a++) wr(0, 4'(a), 8'hFF);
    for (int a = 12; a < 16; a++) begin
      rd(0, 4'(a), v); check("R4 reserved", v, 0);
    end
    rd(0, 4'h0, v); check("R4 DO0 untouched", v, 8'hA5);
    rd(0, 4'h2, v); check("R4 EN0 untouched", v, 8'h00);
  endtask

  task automatic t_cfg();
    logic [7:0] v;
    wr(1, 4'h0, 8'hE3);
    rd(1, 4'h0, v); check("R6 index readback", v, 8'h03);
    wr(1, 4'h1, 8'h7F);
    rd(1, 4'h1, v); check("R6 full cfg", v, 8'h7F);
    wr(1, 4'h1, 8'h00);
    wr(1, 4'h0, 8'h12);
    wr(1, 4'h1, 8'h7F);
    rd(1, 4'h1, v); check("R7 lite cfg", v, 8'h0F);
    wr(1, 4'h1, 8'h00);
  endtask

  task automatic t_pins();
    wr(1, 4'h0, 8'h08);
    wr(1, 4'h1, 8'h01);
    wr(0, 4'h4, 8'h01);
    wait_n(1);
    check("R5 push-pull oe/out", {pin_oe[8], pin_out[8]}, 2'b11);
    wr(1, 4'h1, 8'h03);
    wait_n(1);
    check("R5 open-drain high released", pin_oe[8], 1'b0);
    wr(0, 4'h4, 8'h00);
    wait_n(1);
    check("R5 open-drain low driven", {pin_oe[8], pin_out[8]}, 2'b10);
    wr(1, 4'h1, 8'h00);
  endtask

  task automatic t_edge();
    logic [7:0] v;
    wr(1, 4'h0, 8'h01);
    wr(1, 4'h1, 8'h10);
    pin_in[1] = 1'b1;
    wait_n(4);
    rd(0, 4'h3, v); check("R8 rising sets ST0 while disabled", v, 8'h02);
    check("R12 no irq when disabled", irq, 1'b0);
    wr(0, 4'h2, 8'h02);
    wait_n(1);
    check("R12 irq routed", {irq, smi}, 2'b10);
    pin_in[1] = 1'b0;
    wait_n(4);
    wr(0, 4'h3, 8'h02);
    wait_n(1);
    rd(0, 4'h3, v); check("R8 falling ignored when rising selected", v, 8'h00);
    check("R12 irq drops after clear", irq, 1'b0);
    wr(0, 4'h2, 8'h00);
  endtask

  task automatic t_level_smi();
    logic [7:0] v;
    wr(1, 4'h0, 8'h0D);
    wr(1, 4'h1, 8'h70);
    wr(0, 4'h6, 8'h20);
    pin_in[13] = 1'b1;
    wait_n(4);
    check("R12 smi routed", {irq, smi}, 2'b01);
    wr(0, 4'h7, 8'h20);
    rd(0, 4'h7, v); check("R9 level re-sets", v, 8'h20);
    pin_in[13] = 1'b0;
    wait_n(3);
    wr(0, 4'h7, 8'h20);
    wait_n(1);
    rd(0, 4'h7, v); check("R9 cleared after level gone", v, 8'h00);
    check("R12 smi drops", smi, 1'b0);
    wr(0, 4'h6, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    wr(1, 4'h0, 8'h06);
    wr(1, 4'h1, 8'h10);
    pin_in[6] = 1'b1;
    wait_n(4);
    pin_in[6] = 1'b0;
    wait_n(4);
    wr(0, 4'h3, 8'h00);
    rd(0, 4'h3, v); check("R10 zero write keeps", v, 8'h40);
    pin_in[6] = 1'b1;
    wait_n(2);
    wr(0, 4'h3, 8'h40);
    rd(0, 4'h3, v); check("R11 set wins over clear", v, 8'h40);
    pin_in[6] = 1'b0;
    wait_n(4);
    wr(0, 4'h3, 8'h40);
    rd(0, 4'h3, v); check("R10 clear alone", v, 8'h00);
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_data_out();
    t_data_in();
    t_reserved();
    t_cfg();
    t_pins();
    t_edge();
    t_level_smi();
    t_collision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule